// File: doc/BRIEF.md
# Power-Mode Sequencer

This block tracks the operating mode of a small microcontroller and drives the clock and gating controls that the mode implies. The seven run and low-power modes are high-speed active, medium-speed active, subactive, sleep, subsleep, watch and standby. An eighth state holds the CPU in reset while the main oscillator settles. A sleep-instruction strobe, a direct-transition request, a wake request and a reset request move the controller between modes. A set of control bits (standby select, low-speed on, timer mode, medium-speed select, direct-transfer on) chooses the destination of each move.

The outputs are enables for the main and sub oscillators, a CPU clock enable and source select, a divider shift for the CPU clock, per-peripheral enables and a CPU reset. The oscillators are modelled by an enable output and a stable input. A release counter loaded on a reset request must run down to zero, and the oscillator must report stable, before the CPU leaves reset. A subclock divider value takes effect only when a sleep instruction executes. A control-bit combination that names no destination leaves the mode unchanged and raises a one-cycle illegal flag.

Top module: `pm_mode_ctrl`

## Requirements
- R1: mode_o encodes 0 reset-wait, 1 high-speed, 2 medium-speed, 3 subactive, 4 sleep, 5 subsleep, 6 watch, 7 standby. While rst_n is low and after it rises, mode_o is 0, cpu_rst is 1, main_osc_en is 1 and periph_en is 0. With osc_stable high, the first edge after reset moves to mode 1.
- R2: A reset_req loads the release counter from rel_load on the edge where it is sampled. rel_ready is high only in mode 0 with osc_stable high and the counter at zero, which is rel_load edges after the load. The controller moves to mode 1 on the edge where rel_ready is high.
- R3: In mode 3 a sleep_stb selects a destination from the bits stby, lowspd, tmr, dtx and msel. It goes to mode 5 when dtx=0, stby=0, lowspd=1 and tmr=1. It goes to mode 6 when dtx=0, stby=1 and tmr=1. When dtx=1 and stby, lowspd and tmr are all 0, it goes to mode 2 if msel=1 and to mode 1 if msel=0.
- R4: In mode 1 or 2 a sleep_stb selects a destination. It goes to mode 6 when stby=1 and tmr=1. It goes to mode 7 when stby=1, lowspd=0 and tmr=0. It goes to mode 4 when stby=0 and lowspd=0.
- R5: In mode 1 or 2 a direct_req with no sleep_stb goes to mode 3 when lowspd=1. When lowspd=0 it goes from mode 2 to mode 1 if msel=0, and from mode 1 to mode 2 if msel=1.
- R6: A sleep_stb or direct_req whose bits match no case of R3 to R5 leaves mode_o unchanged. illegal_trn is then high for exactly the following cycle.
- R7: main_osc_en is high in modes 0, 1, 2 and 4. sub_osc_en is high in every mode except 7. cpu_clk_en is high in modes 1, 2 and 3. cpu_clk_sub is high only in mode 3.
- R8: periph_en is all ones in modes 1, 2 and 4, and all zeros in modes 0, 6 and 7. In modes 3 and 5 the low-speed-gated bits 3:0 (analog converter, PWM, pulse timer, I2C) are 0 and bits 7:4 are 1.
- R9: clk_shift is the log2 of the CPU clock divisor. In mode 1 it is 0. In mode 2 it is ms_div+2. In modes without a CPU clock it is 0.
- R10: In mode 3, clk_shift follows the applied subclock code: 00 gives 3 (divide by 8), 01 gives 2, and 1x gives 1.
- R11: sub_div_wr becomes the applied subclock code only on an edge where sleep_stb is accepted in mode 1, 2 or 3. The applied code resets to 00.
- R12: wake_req in mode 5 goes to mode 3. In modes 4, 6 and 7 it goes to mode 3 if lowspd=1, otherwise to mode 2 if msel=1, otherwise to mode 1.
- R13: reset_req takes precedence over every other request and moves any mode to mode 0 with cpu_rst high on the next cycle.
- R14: direct_req in mode 3 is ignored: mode_o stays 3 and illegal_trn stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sleep_stb | input | 1 | Sleep instruction executed |
| direct_req | input | 1 | Direct mode-transition request |
| wake_req | input | 1 | Wake event from a sleeping mode |
| reset_req | input | 1 | Reset source request |
| ctl_stby | input | 1 | Standby-select control bit |
| ctl_lowspd | input | 1 | Low-speed-on control bit |
| ctl_tmr | input | 1 | Timer-mode control bit |
| ctl_msel | input | 1 | Medium-speed-select control bit |
| ctl_dtx | input | 1 | Direct-transfer-on control bit |
| ms_div | input | 2 | Medium-speed divider field |
| sub_div_wr | input | 2 | Written subclock divider field |
| rel_load | input | CNT_W | Release-time count |
| osc_stable | input | 1 | Main oscillator reports stable |
| mode_o | output | 3 | Current mode code |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Sub oscillator enable |
| cpu_rst | output | 1 | CPU held in reset |
| rel_ready | output | 1 | Reset release condition met |
| cpu_clk_en | output | 1 | CPU clock running |
| cpu_clk_sub | output | 1 | CPU clock taken from subclock |
| clk_shift | output | 3 | log2 of CPU clock divisor |
| periph_en | output | NP | Per-peripheral clock enables |
| illegal_trn | output | 1 | Rejected transition, one cycle |

## Verification
A wrong next-mode decision shows on mode_o one cycle after the strobe. Within the same cycle, the oscillator enables, the peripheral mask and clk_shift take values that belong to the wrong mode. A wrong applied subclock code stays hidden until the controller sits in subactive, where clk_shift shows it at once. The bench therefore forces a sleep in subactive for each code. A release counter that is off by one moves the reset-wait exit by one edge, so rel_ready and mode_o are sampled at the exact edge count.

// File: rtl/pm_pkg.sv
// Package: shared mode encoding, control-bit bundle and subclock shift decode.
// Assumes 3-bit mode codes; reset-wait is code 0.
package pm_pkg;

    typedef enum logic [2:0] {
        M_RWAIT  = 3'd0,
        M_HIGH   = 3'd1,
        M_MED    = 3'd2,
        M_SUB    = 3'd3,
        M_SLEEP  = 3'd4,
        M_SUBSLP = 3'd5,
        M_WATCH  = 3'd6,
        M_STBY   = 3'd7
    } pm_mode_e;

    typedef struct packed {
        logic stby;
        logic lowspd;
        logic tmr;
        logic msel;
        logic dtx;
    } pm_ctl_t;

    // Subclock code to divider shift: 00 -> /8, 01 -> /4, 1x -> /2.
    function automatic logic [2:0] sub_shift(input logic [1:0] code);
        if (code[1])      return 3'd1;
        else if (code[0]) return 3'd2;
        else              return 3'd3;
    endfunction

endpackage

// File: rtl/pm_next_mode.sv
// Next-mode decoder. Pure combinational: picks the next mode from the current
// mode, the request strobes and the control bits. Reset request wins over all.
// Flags combinations with no destination and marks accepted sleep instructions.
module pm_next_mode
    import pm_pkg::*;
(
    input  pm_mode_e cur,
    input  logic     sleep_stb,
    input  logic     direct_req,
    input  logic     wake_req,
    input  logic     reset_req,
    input  logic     rel_ready,
    input  pm_ctl_t  ctl,
    output pm_mode_e nxt,
    output logic     illegal,
    output logic     div_apply
);

    // Helper: return destination from a sleeping mode.
    pm_mode_e wake_dst;
    always_comb begin
        if (ctl.lowspd)    wake_dst = M_SUB;
        else if (ctl.msel) wake_dst = M_MED;
        else               wake_dst = M_HIGH;
    end

    // Transition decode per current mode.
    always_comb begin
        nxt       = cur;
        illegal   = 1'b0;
        div_apply = 1'b0;
        if (reset_req) begin
            nxt = M_RWAIT;
        end else begin
            case (cur)
                M_RWAIT: begin
                    if (rel_ready) nxt = M_HIGH;
                end
                M_HIGH, M_MED: begin
                    if (sleep_stb) begin
                        div_apply = 1'b1;
                        if (ctl.stby && ctl.tmr)                      nxt = M_WATCH;
                        else if (ctl.stby && !ctl.lowspd && !ctl.tmr) nxt = M_STBY;
                        else if (!ctl.stby && !ctl.lowspd)            nxt = M_SLEEP;
                        else                                          illegal = 1'b1;
                    end else if (direct_req) begin
                        if (ctl.lowspd)                         nxt = M_SUB;
                        else if (!ctl.msel && cur == M_MED)     nxt = M_HIGH;
                        else if (ctl.msel && cur == M_HIGH)     nxt = M_MED;
                        else                                    illegal = 1'b1;
                    end
                end
                M_SUB: begin
                    if (sleep_stb) begin
                        div_apply = 1'b1;
                        if (!ctl.dtx && !ctl.stby && ctl.lowspd && ctl.tmr)
                            nxt = M_SUBSLP;
                        else if (!ctl.dtx && ctl.stby && ctl.tmr)
                            nxt = M_WATCH;
                        else if (ctl.dtx && !ctl.stby && !ctl.lowspd && !ctl.tmr)
                            nxt = ctl.msel ? M_MED : M_HIGH;
                        else
                            illegal = 1'b1;
                    end
                end
                M_SUBSLP: begin
                    if (wake_req) nxt = M_SUB;
                end
                default: begin
                    if (wake_req) nxt = wake_dst;
                end
            endcase
        end
    end

endmodule

// File: rtl/pm_rel_timer.sv
// Reset-release timer. Loads a count on a reset request and counts down to
// zero. Ready only in reset-wait with the oscillator stable and count at zero.
// Assumes the load strobe is a single-cycle or held request.
module pm_rel_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    input  logic          waiting,
    input  logic          osc_stable,
    output logic          ready
);

    logic [CW-1:0] cnt_q;

    // Count register: load on request, else run down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    // Release condition.
    always_comb ready = waiting && osc_stable && (cnt_q == '0);

endmodule

// File: rtl/pm_out_dec.sv
// Output decoder: oscillator, CPU clock and peripheral enables from the mode.
// Bits set in LS_MASK are the peripherals gated off in the low-speed modes.
module pm_out_dec
    import pm_pkg::*;
#(
    parameter int          NP      = 8,
    parameter logic [NP-1:0] LS_MASK = NP'(4'hF)
) (
    input  pm_mode_e      mode,
    input  logic [1:0]    ms_div,
    input  logic [1:0]    sub_code,
    output logic          main_osc_en,
    output logic          sub_osc_en,
    output logic          cpu_rst,
    output logic          cpu_clk_en,
    output logic          cpu_clk_sub,
    output logic [2:0]    clk_shift,
    output logic [NP-1:0] periph_en
);

    localparam logic [NP-1:0] ALL_ON = '1;

    // Oscillator and CPU clock controls per mode.
    always_comb begin
        main_osc_en = (mode == M_RWAIT) || (mode == M_HIGH) ||
                      (mode == M_MED)   || (mode == M_SLEEP);
        sub_osc_en  = (mode != M_STBY);
        cpu_rst     = (mode == M_RWAIT);
        cpu_clk_en  = (mode == M_HIGH) || (mode == M_MED) || (mode == M_SUB);
        cpu_clk_sub = (mode == M_SUB);
    end

    // Divider shift per mode.
    always_comb begin
        case (mode)
            M_MED:   clk_shift = 3'({1'b0, ms_div}) + 3'd2;
            M_SUB:   clk_shift = sub_shift(sub_code);
            default: clk_shift = 3'd0;
        endcase
    end

    // Peripheral gating per mode.
    always_comb begin
        case (mode)
            M_HIGH, M_MED, M_SLEEP: periph_en = ALL_ON;
            M_SUB, M_SUBSLP:        periph_en = ALL_ON & ~LS_MASK;
            default:                periph_en = '0;
        endcase
    end

endmodule

// File: rtl/pm_mode_ctrl.sv
// Top: power-mode sequencer. Holds the mode register, the applied subclock
// divider code and the registered illegal flag; instantiates the decoder,
// the release timer and the output decoder. Synchronous active-low reset.
module pm_mode_ctrl
    import pm_pkg::*;
#(
    parameter int            CNT_W   = 16,
    parameter int            NP      = 8,
    parameter logic [NP-1:0] LS_MASK = NP'(4'hF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep_stb,
    input  logic             direct_req,
    input  logic             wake_req,
    input  logic             reset_req,
    input  logic             ctl_stby,
    input  logic             ctl_lowspd,
    input  logic             ctl_tmr,
    input  logic             ctl_msel,
    input  logic             ctl_dtx,
    input  logic [1:0]       ms_div,
    input  logic [1:0]       sub_div_wr,
    input  logic [CNT_W-1:0] rel_load,
    input  logic             osc_stable,
    output logic [2:0]       mode_o,
    output logic             main_osc_en,
    output logic             sub_osc_en,
    output logic             cpu_rst,
    output logic             rel_ready,
    output logic             cpu_clk_en,
    output logic             cpu_clk_sub,
    output logic [2:0]       clk_shift,
    output logic [NP-1:0]    periph_en,
    output logic             illegal_trn
);

    pm_mode_e mode_q, mode_d;
    pm_ctl_t  ctl;
    logic     ill_d, ill_q, apply;
    logic [1:0] sub_code_q;

    // Bundle the control bits.
    always_comb ctl = '{stby: ctl_stby, lowspd: ctl_lowspd, tmr: ctl_tmr,
                        msel: ctl_msel, dtx: ctl_dtx};

    pm_next_mode u_next (
        .cur        (mode_q),
        .sleep_stb  (sleep_stb),
        .direct_req (direct_req),
        .wake_req   (wake_req),
        .reset_req  (reset_req),
        .rel_ready  (rel_ready),
        .ctl        (ctl),
        .nxt        (mode_d),
        .illegal    (ill_d),
        .div_apply  (apply)
    );

    pm_rel_timer #(.CW(CNT_W)) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (reset_req),
        .load_val   (rel_load),
        .waiting    (mode_q == M_RWAIT),
        .osc_stable (osc_stable),
        .ready      (rel_ready)
    );

    // Mode, illegal flag and applied subclock code registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q     <= M_RWAIT;
            ill_q      <= 1'b0;
            sub_code_q <= 2'b00;
        end else begin
            mode_q <= mode_d;
            ill_q  <= ill_d;
            if (apply) sub_code_q <= sub_div_wr;
        end
    end

    pm_out_dec #(.NP(NP), .LS_MASK(LS_MASK)) u_out (
        .mode        (mode_q),
        .ms_div      (ms_div),
        .sub_code    (sub_code_q),
        .main_osc_en (main_osc_en),
        .sub_osc_en  (sub_osc_en),
        .cpu_rst     (cpu_rst),
        .cpu_clk_en  (cpu_clk_en),
        .cpu_clk_sub (cpu_clk_sub),
        .clk_shift   (clk_shift),
        .periph_en   (periph_en)
    );

    // Port drives.
    always_comb begin
        mode_o      = mode_q;
        illegal_trn = ill_q;
    end

endmodule

// File: rtl/pm_mode_chk.sv
// Checker for pm_mode_ctrl: port-level temporal properties, bound to the top.
module pm_mode_chk #(
    parameter int            NP      = 8,
    parameter logic [NP-1:0] LS_MASK = NP'(4'hF)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          sleep_stb,
    input logic          direct_req,
    input logic          reset_req,
    input logic          osc_stable,
    input logic [2:0]    mode_o,
    input logic          main_osc_en,
    input logic          cpu_rst,
    input logic          rel_ready,
    input logic          cpu_clk_sub,
    input logic [NP-1:0] periph_en,
    input logic          illegal_trn
);

    AST_RESET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        reset_req |=> (mode_o == 3'd0) && cpu_rst); // R13

    AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_trn |-> (mode_o == $past(mode_o))); // R6

    AST_SUB_MAIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> (!main_osc_en && cpu_clk_sub)); // R7

    AST_SUB_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd3) |-> ((periph_en & LS_MASK) == '0)); // R8

    AST_RELEASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd1) && ($past(mode_o) == 3'd0)) |->
            ($past(rel_ready) && $past(osc_stable))); // R2

    AST_SUB_EXIT_SLEEP: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_o) == 3'd3) && (mode_o != 3'd3) && (mode_o != 3'd0)) |->
            $past(sleep_stb)); // R3

    AST_SUB_DIRECT_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd3) && direct_req && !sleep_stb && !reset_req) |=>
            ((mode_o == 3'd3) && !illegal_trn)); // R14

endmodule

bind pm_mode_ctrl pm_mode_chk #(.NP(NP), .LS_MASK(LS_MASK)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sleep_stb   (sleep_stb),
    .direct_req  (direct_req),
    .reset_req   (reset_req),
    .osc_stable  (osc_stable),
    .mode_o      (mode_o),
    .main_osc_en (main_osc_en),
    .cpu_rst     (cpu_rst),
    .rel_ready   (rel_ready),
    .cpu_clk_sub (cpu_clk_sub),
    .periph_en   (periph_en),
    .illegal_trn (illegal_trn)
);

// File: tb/sim_pm_mode_ctrl.sv
module sim_pm_mode_ctrl;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sleep_stb = 0, direct_req = 0, wake_req = 0, reset_req = 0;
    logic ctl_stby = 0, ctl_lowspd = 0, ctl_tmr = 0, ctl_msel = 0, ctl_dtx = 0;
    logic [1:0] ms_div = 0, sub_div_wr = 0;
    logic [15:0] rel_load = 0;
    logic osc_stable = 0;
    logic [2:0] mode_o, clk_shift;
    logic main_osc_en, sub_osc_en, cpu_rst, rel_ready, cpu_clk_en, cpu_clk_sub, illegal_trn;
    logic [7:0] periph_en;

    int total = 0, bad = 0;
    bit done = 0;
    int sa_model = 0;

    always #5 clk = ~clk;

    pm_mode_ctrl u0 (.*);

    task automatic check(string tag, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic set_ctl(logic [4:0] c);
        {ctl_stby, ctl_lowspd, ctl_tmr, ctl_msel, ctl_dtx} = c;
    endtask

    // Expected outputs for a mode (R7, R8, R9, R10).
    task automatic check_outs(int m);
        int sh;
        int pe;
        check("R7 main_osc_en", main_osc_en, (m == 0 || m == 1 || m == 2 || m == 4) ? 1 : 0);
        check("R7 sub_osc_en", sub_osc_en, (m != 7) ? 1 : 0);
        check("R7 cpu_clk_en", cpu_clk_en, (m >= 1 && m <= 3) ? 1 : 0);
        check("R7 cpu_clk_sub", cpu_clk_sub, (m == 3) ? 1 : 0);
        pe = (m == 1 || m == 2 || m == 4) ? 255 : (m == 3 || m == 5) ? 240 : 0;
        check("R8 periph_en", periph_en, pe);
        if (m == 1) sh = 0;
        else if (m == 2) sh = ms_div + 2;
        else if (m == 3) sh = (sa_model >= 2) ? 1 : (sa_model == 1) ? 2 : 3;
        else sh = 0;
        check(m == 3 ? "R10 clk_shift" : "R9 clk_shift", clk_shift, sh);
    endtask

    // Expected destination of a sleep or direct event (R3, R4, R5, R6, R14).
    function automatic int exp_next(int src, bit slp, logic [4:0] c, output bit ill);
        bit s, l, t, m, d;
        {s, l, t, m, d} = c;
        ill = 0;
        if (src == 3) begin
            if (!slp) return 3;
            if (!d && !s && l && t) return 5;
            if (!d && s && t) return 6;
            if (d && !s && !l && !t) return m ? 2 : 1;
            ill = 1; return 3;
        end
        if (slp) begin
            if (s && t) return 6;
            if (s && !l && !t) return 7;
            if (!s && !l) return 4;
            ill = 1; return src;
        end
        if (l) return 3;
        if (!m && src == 2) return 1;
        if (m && src == 1) return 2;
        ill = 1; return src;
    endfunction

    task automatic go_high();
        rel_load = 0; osc_stable = 1; reset_req = 1;
        step();
        reset_req = 0;
        step();
    endtask

    task automatic go_to(int m);
        go_high();
        if (m == 1) return;
        set_ctl(m == 2 ? 5'b00010 : 5'b01000);
        direct_req = 1;
        step();
        direct_req = 0;
    endtask

    // Watchdog.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        bit ill;
        int e;
        // R1: reset state
        step(); step();
        check("R1 mode in reset", mode_o, 0);
        check("R1 cpu_rst in reset", cpu_rst, 1);
        rst_n = 1;
        step();
        check("R1 mode after reset", mode_o, 0);
        check_outs(0);
        check("R1 cpu_rst after reset", cpu_rst, 1);
        check("R2 no ready while unstable", rel_ready, 0);
        osc_stable = 1;
        step();
        check("R1 release to high-speed", mode_o, 1);
        check_outs(1);

        // R2: release counting, stable from the start and late stable
        for (int n = 1; n <= 6; n++) begin
            rel_load = 16'(n); osc_stable = (n % 2 == 0); reset_req = 1;
            step();
            reset_req = 0;
            check("R2 wait after request", mode_o, 0);
            for (int k = 1; k < n; k++) step();
            check("R2 not ready before count", rel_ready, 0);
            step();
            check("R2 still waiting at zero", mode_o, 0);
            check("R2 ready at zero", rel_ready, osc_stable ? 1 : 0);
            if (!osc_stable) begin
                step();
                check("R2 held while unstable", mode_o, 0);
                osc_stable = 1;
                #1 check("R2 ready once stable", rel_ready, 1);
            end
            step();
            check("R2 released", mode_o, 1);
        end

        // R3..R6, R14: sweep of events from active modes, all control combos
        sub_div_wr = 2'b01;
        for (int src = 1; src <= 3; src++) begin
            for (int ev = 0; ev < 2; ev++) begin
                for (int c = 0; c < 32; c++) begin
                    go_to(src);
                    set_ctl(5'(c));
                    ms_div = 2'(c);
                    if (ev == 1) sleep_stb = 1; else direct_req = 1;
                    step();
                    sleep_stb = 0; direct_req = 0;
                    if (ev == 1) sa_model = 1;
                    e = exp_next(src, ev == 1, 5'(c), ill);
                    check(src == 3 ? (ev == 1 ? "R3 next mode" : "R14 direct ignored")
                                   : (ev == 1 ? "R4 next mode" : "R5 next mode"), mode_o, e);
                    check("R6 illegal flag", illegal_trn, ill);
                    check_outs(e);
                    step();
                    check("R6 flag one cycle", illegal_trn, 0);
                    check("R6 mode held", mode_o, e);
                end
            end
        end

        // R10, R11: each subclock code applied by a rejected sleep in subactive
        for (int k = 0; k < 4; k++) begin
            go_to(3);
            sub_div_wr = 2'(k);
            step(); step();
            check_outs(3);
            check("R11 code not applied yet", clk_shift,
                  (sa_model >= 2) ? 1 : (sa_model == 1) ? 2 : 3);
            set_ctl(5'b00000); sleep_stb = 1;
            step();
            sleep_stb = 0;
            sa_model = k;
            check("R11 stays subactive", mode_o, 3);
            check("R10 shift after sleep", clk_shift, (k >= 2) ? 1 : (k == 1) ? 2 : 3);
        end

        // R12, R13: wake from each sleeping mode, then reset priority
        for (int d = 4; d <= 7; d++) begin
            for (int w = 0; w < 4; w++) begin
                logic [4:0] ec;
                int src;
                src = (d == 5 || d == 6) ? 3 : 2;
                ec = (d == 4) ? 5'b00000 : (d == 5) ? 5'b01100 : (d == 6) ? 5'b10100 : 5'b10000;
                go_to(src);
                set_ctl(ec); sleep_stb = 1;
                step();
                sleep_stb = 0;
                sa_model = sub_div_wr;
                check("R12 entered sleeping mode", mode_o, d);
                check_outs(d);
                ctl_lowspd = w[1]; ctl_msel = w[0]; wake_req = 1;
                step();
                wake_req = 0;
                e = (d == 5) ? 3 : w[1] ? 3 : w[0] ? 2 : 1;
                check("R12 wake destination", mode_o, e);
                sleep_stb = 1; direct_req = 1; wake_req = 1; reset_req = 1;
                rel_load = 3;
                step();
                sleep_stb = 0; direct_req = 0; wake_req = 0; reset_req = 0;
                check("R13 reset wins", mode_o, 0);
                check("R13 cpu_rst", cpu_rst, 1);
            end
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule